// File: doc/BRIEF.md
# UART Interrupt Identifier and Arbiter

This block decides which of a FIFO-based UART's interrupt sources is reported to the host, and when the single interrupt line is raised. It watches five sources: a sticky line-error condition, the receive FIFO fill level against a selectable trigger, a receive character timeout, a transmitter-empty condition and a modem-change flag. Each source is gated by a 4-bit enable register. The sources are ranked by a fixed priority and encoded into an 8-bit identification byte for the host to read.

The block owns three pieces of state. A timeout counter counts character-time ticks while the receive FIFO sits idle and not empty. A two-state machine tracks the transmitter-empty interrupt: `THR_WAIT` goes to `THR_PEND` on a rising edge of the empty condition that is not matched by a write in the same cycle. `THR_PEND` goes back to `THR_WAIT` on a holding-register write, or when an identification read begins while that interrupt is the one shown. A second two-state machine holds the identification byte during a host read: `FRZ_LIVE` goes to `FRZ_HELD` when a read begins, and `FRZ_HELD` goes back to `FRZ_LIVE` when the read strobe drops. Events that arrive during the read are recorded and show once the read ends. The FIFOs, the serializers and the register decode sit outside this block and drive its event inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: The low nibble of the identification byte is 0110 for line status (highest), then 0100 for receive data at trigger, 1100 for character timeout (same rank as receive data, receive data shown first), 0010 for transmitter empty, 0000 for modem change (lowest), and 0001 when nothing enabled is pending.
- R2: Enable bit 0 gates receive data and timeout, bit 1 transmitter empty, bit 2 line status and bit 3 modem change. A disabled source is absent from the code. `irq` is high exactly when some enabled source is pending.
- R3: Bits 5:4 of the identification byte are always 0. Bits 7:6 both equal `fifo_mode`.
- R4: In FIFO mode, `trig_sel` 00/01/10/11 selects a receive trigger of 1/4/8/14 characters. Receive-data is pending while `rx_count` is at or above the trigger and drops as soon as it falls below.
- R5: In FIFO mode, a timeout becomes pending on the cycle after the fourth `char_tick` during which the FIFO held at least one character and no push or pop occurred. With the FIFO empty, no timeout is raised.
- R6: A push or a pop resets the timeout count, and a pending timeout clears on the cycle after a pop. Outside FIFO mode, the count stays at zero.
- R7: Transmitter empty becomes pending on the cycle after a rising edge of `tx_empty`. It does not re-arm while `tx_empty` merely stays high.
- R8: Transmitter empty clears after a `thr_wr` pulse, or when an identification read begins while code 0010 is shown. A read that begins while another code is shown leaves it pending.
- R9: While `iir_rd` stays high, the identification byte keeps the value it had when the read began. Events recorded during the read appear once `iir_rd` drops. `irq` follows the live state throughout.
- R10: Line status becomes pending on the cycle after `err_set` and clears on the cycle after `lsr_rd`. When both arrive in the same cycle, the set wins.
- R11: Outside FIFO mode, the receive trigger is one character regardless of `trig_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | FIFO mode enable |
| ier | input | 4 | Source enables (bit0 rx/timeout, bit1 tx empty, bit2 line status, bit3 modem) |
| trig_sel | input | 2 | Receive trigger select |
| rx_count | input | CNT_W (5) | Characters currently held in the receive FIFO |
| rx_push | input | 1 | Pulse: a character entered the receive FIFO |
| rx_pop | input | 1 | Pulse: host popped a receive character |
| char_tick | input | 1 | Pulse once per character time |
| err_set | input | 1 | Pulse: overrun, parity, framing or break detected |
| lsr_rd | input | 1 | Pulse: host read of line status |
| tx_empty | input | 1 | Transmit holding/FIFO empty level |
| thr_wr | input | 1 | Pulse: host write of transmit holding register |
| modem_chg | input | 1 | Modem status change flag (level) |
| iir_rd | input | 1 | High for the duration of a host identification read |
| irq | output | 1 | Interrupt request |
| iir | output | 8 | Identification byte |

## Verification
The priority logic is swept over every combination of the four level-type sources and all sixteen enable values, so each ranking and each masking shows up separately. The trigger comparison is swept over every FIFO count from 0 to 16 at each trigger select, and again outside FIFO mode. This separates the at-level case from the below-level case at every boundary. Timeout and transmitter-empty behaviour is driven through ordered event sequences: ticks just short of and exactly at the limit, resets by push and pop, an empty FIFO, clears by write and by read, a read while another code is shown, and re-arming with a held versus a new edge. A freeze sequence injects a line error during a held read to show that the code is held while `irq` is not.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic {
        THR_WAIT = 1'b0,
        THR_PEND = 1'b1
    } thr_state_e;

    typedef enum logic {
        FRZ_LIVE = 1'b0,
        FRZ_HELD = 1'b1
    } frz_state_e;

    localparam logic [3:0] CODE_NONE  = 4'b0001;
    localparam logic [3:0] CODE_LINE  = 4'b0110;
    localparam logic [3:0] CODE_RXDAT = 4'b0100;
    localparam logic [3:0] CODE_TOUT  = 4'b1100;
    localparam logic [3:0] CODE_THRE  = 4'b0010;
    localparam logic [3:0] CODE_MODEM = 4'b0000;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_rxto.sv
module uart_irq_rxto #(
    parameter int TO_CHARS = 4,
    localparam int TO_W = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic nonempty,
    input  logic activity,
    input  logic tick,
    output logic timed_out
);
    logic [TO_W-1:0] tcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (!enable || !nonempty || activity) begin
            tcnt <= '0;
        end else if (tick && (tcnt != TO_W'(TO_CHARS))) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    assign timed_out = enable && nonempty && (tcnt == TO_W'(TO_CHARS));

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic thr_wr,
    input  logic rd_clear,
    output logic pending
);
    thr_state_e state, state_nx;
    logic       empty_q;
    logic       rise;

    assign rise = tx_empty && !empty_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= THR_WAIT;
            empty_q <= 1'b0;
        end else begin
            state   <= state_nx;
            empty_q <= tx_empty;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            THR_WAIT: if (rise && !thr_wr)       state_nx = THR_PEND;
            THR_PEND: if (thr_wr || rd_clear)    state_nx = THR_WAIT;
            default:                             state_nx = THR_WAIT;
        endcase
    end

    assign pending = (state == THR_PEND);

endmodule

// File: rtl/uart_irq_freeze.sv
module uart_irq_freeze
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic [7:0] live,
    output logic [7:0] shown,
    output logic       rd_start
);
    frz_state_e state, state_nx;
    logic [7:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FRZ_LIVE;
            held  <= 8'h01;
        end else begin
            state <= state_nx;
            if (rd_start) held <= live;
        end
    end

    always_comb begin
        state_nx = state;
        rd_start = 1'b0;
        unique case (state)
            FRZ_LIVE: if (rd) begin
                rd_start = 1'b1;
                state_nx = FRZ_HELD;
            end
            FRZ_HELD: if (!rd) state_nx = FRZ_LIVE;
            default:  state_nx = FRZ_LIVE;
        endcase
    end

    assign shown = (state == FRZ_HELD && rd) ? held : live;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TO_CHARS   = 4,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [3:0]       ier,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    input  logic             err_set,
    input  logic             lsr_rd,
    input  logic             tx_empty,
    input  logic             thr_wr,
    input  logic             modem_chg,
    input  logic             iir_rd,
    output logic             irq,
    output logic [7:0]       iir
);
    logic             line_pend;
    logic             rx_at_trig;
    logic             tout_pend;
    logic             thre_pend;
    logic             rd_start;
    logic             rd_clear;
    logic [3:0]       code_live;
    logic [7:0]       iir_live;
    logic [CNT_W-1:0] level;

    // Line-status latch: set has precedence over the clearing read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       line_pend <= 1'b0;
        else if (err_set) line_pend <= 1'b1;
        else if (lsr_rd)  line_pend <= 1'b0;
    end

    assign level      = fifo_mode ? CNT_W'(trig_level(trig_sel)) : CNT_W'(1);
    assign rx_at_trig = (rx_count >= level);

    uart_irq_rxto #(.TO_CHARS(TO_CHARS)) u_rxto (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (fifo_mode),
        .nonempty  (rx_count != '0),
        .activity  (rx_push || rx_pop),
        .tick      (char_tick),
        .timed_out (tout_pend)
    );

    uart_irq_thre u_thre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_empty (tx_empty),
        .thr_wr   (thr_wr),
        .rd_clear (rd_clear),
        .pending  (thre_pend)
    );

    // Fixed-priority encoder over the enabled sources.
    always_comb begin
        if (line_pend && ier[2])       code_live = CODE_LINE;
        else if (rx_at_trig && ier[0]) code_live = CODE_RXDAT;
        else if (tout_pend && ier[0])  code_live = CODE_TOUT;
        else if (thre_pend && ier[1])  code_live = CODE_THRE;
        else if (modem_chg && ier[3])  code_live = CODE_MODEM;
        else                           code_live = CODE_NONE;
    end

    assign iir_live = {fifo_mode, fifo_mode, 2'b00, code_live};
    assign rd_clear = rd_start && (code_live == CODE_THRE);
    assign irq      = !code_live[0];

    uart_irq_freeze u_freeze (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (iir_rd),
        .live     (iir_live),
        .shown    (iir),
        .rd_start (rd_start)
    );

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ier,
    input logic       err_set,
    input logic       thr_wr,
    input logic       iir_rd,
    input logic       irq,
    input logic [7:0] iir
);
    // R2: outside a read the line and the shown code agree
    assert_irq_tracks_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !iir_rd |-> (irq == !iir[0]));

    // R2: nothing enabled, nothing raised
    assert_no_enable_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'b0000) |-> !irq);

    // R9: the byte is held across a continuing read
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && $past(iir_rd)) |-> $stable(iir));

    // R8: a holding-register write removes the transmitter-empty code
    assert_thr_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (iir_rd || iir[3:0] != 4'b0010));

    // R10: a line error with its enable set raises the request
    assert_line_err_raises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set && ier[2]) |=> (irq || !ier[2]));

    // R1: the line-status code only appears with its enable set
    assert_line_code_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!iir_rd && iir[3:0] == 4'b0110) |-> ier[2]);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ier     (ier),
    .err_set (err_set),
    .thr_wr  (thr_wr),
    .iir_rd  (iir_rd),
    .irq     (irq),
    .iir     (iir)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b0;
    logic [3:0] ier = 4'h0;
    logic [1:0] trig_sel = 2'b00;
    logic [4:0] rx_count = 5'd0;
    logic       rx_push = 1'b0, rx_pop = 1'b0, char_tick = 1'b0;
    logic       err_set = 1'b0, lsr_rd = 1'b0;
    logic       tx_empty = 1'b0, thr_wr = 1'b0, modem_chg = 1'b0;
    logic       iir_rd = 1'b0;
    logic       irq;
    logic [7:0] iir;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .ier(ier),
        .trig_sel(trig_sel), .rx_count(rx_count), .rx_push(rx_push),
        .rx_pop(rx_pop), .char_tick(char_tick), .err_set(err_set),
        .lsr_rd(lsr_rd), .tx_empty(tx_empty), .thr_wr(thr_wr),
        .modem_chg(modem_chg), .iir_rd(iir_rd), .irq(irq), .iir(iir)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] exp_code(input bit ls, input bit rd, input bit th,
                                            input bit md, input logic [3:0] en);
        if (ls && en[2]) return 4'b0110;
        if (rd && en[0]) return 4'b0100;
        if (th && en[1]) return 4'b0010;
        if (md && en[3]) return 4'b0000;
        return 4'b0001;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // Reset state
        chk("R2 reset iir", iir, 8'h01);
        chk("R2 reset irq", {7'd0, irq}, 8'h00);

        // R4 / R3: trigger sweep in FIFO mode
        fifo_mode = 1'b1;
        ier = 4'b0001;
        for (int t = 0; t < 4; t++) begin
            for (int c = 0; c <= 16; c++) begin
                int lvl;
                lvl = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
                trig_sel = 2'(t);
                rx_count = 5'(c);
                #1;
                chk("R4 trigger", iir, (c >= lvl) ? 8'hC4 : 8'hC1);
                chk("R3 irq level", {7'd0, irq}, (c >= lvl) ? 8'h01 : 8'h00);
            end
        end
        // R11: non-FIFO mode uses a trigger of one
        fifo_mode = 1'b0;
        trig_sel = 2'b11;
        for (int c = 0; c <= 3; c++) begin
            rx_count = 5'(c);
            #1;
            chk("R11 trigger one", iir, (c >= 1) ? 8'h04 : 8'h01);
        end
        rx_count = 5'd0;
        step();

        // R1 / R2: sources x enables, FIFO mode, trigger of one, no ticks
        fifo_mode = 1'b1;
        trig_sel = 2'b00;
        for (int m = 0; m < 16; m++) begin
            bit ls, rd, th, md;
            ls = m[0]; rd = m[1]; th = m[2]; md = m[3];
            tx_empty = 1'b0; thr_wr = 1'b1; lsr_rd = 1'b1;
            modem_chg = md; rx_count = rd ? 5'd1 : 5'd0;
            step();
            thr_wr = 1'b0; lsr_rd = 1'b0;
            err_set = ls; tx_empty = th;
            step();
            err_set = 1'b0; tx_empty = 1'b0;
            step();
            for (int e = 0; e < 16; e++) begin
                logic [3:0] ec;
                ier = 4'(e);
                ec = exp_code(ls, rd, th, md, 4'(e));
                #1;
                chk("R1 priority", iir, {4'b1100, ec});
                chk("R2 mask irq", {7'd0, irq}, {7'd0, ec != 4'b0001});
            end
        end
        thr_wr = 1'b1; lsr_rd = 1'b1; modem_chg = 1'b0; rx_count = 5'd0;
        step();
        thr_wr = 1'b0; lsr_rd = 1'b0;

        // R5 / R6: timeout
        ier = 4'b0001; trig_sel = 2'b11; rx_count = 5'd2;
        rx_push = 1'b1; step(); rx_push = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            char_tick = 1'b1; step(); char_tick = 1'b0;
            chk("R5 below limit", iir, 8'hC1);
        end
        char_tick = 1'b1; step(); char_tick = 1'b0;
        chk("R5 timeout", iir, 8'hCC);
        rx_pop = 1'b1; step(); rx_pop = 1'b0;
        chk("R6 pop clears", iir, 8'hC1);
        for (int k = 1; k <= 3; k++) begin
            char_tick = 1'b1; step(); char_tick = 1'b0;
        end
        rx_push = 1'b1; step(); rx_push = 1'b0;
        char_tick = 1'b1; step(); char_tick = 1'b0;
        chk("R6 push resets count", iir, 8'hC1);
        for (int k = 1; k <= 3; k++) begin
            char_tick = 1'b1; step(); char_tick = 1'b0;
        end
        chk("R6 timeout after reset", iir, 8'hCC);
        rx_count = 5'd0;
        step();
        for (int k = 1; k <= 5; k++) begin
            char_tick = 1'b1; step(); char_tick = 1'b0;
        end
        chk("R5 empty fifo no timeout", iir, 8'h C1);
        // R6: count held at zero outside FIFO mode
        fifo_mode = 1'b0; rx_count = 5'd2;
        for (int k = 1; k <= 5; k++) begin
            char_tick = 1'b1; step(); char_tick = 1'b0;
        end
        fifo_mode = 1'b1;
        #1;
        chk("R6 no count outside FIFO mode", iir, 8'hC1);
        rx_count = 5'd0;
        fifo_mode = 1'b0;
        step();

        // R7 / R8 / R9: transmitter empty and freeze
        ier = 4'b0010;
        tx_empty = 1'b1; step();
        chk("R7 rising edge pends", iir, 8'h02);
        iir_rd = 1'b1; step();
        chk("R9 held during read", iir, 8'h02);
        chk("R8 read clears irq", {7'd0, irq}, 8'h00);
        ier = 4'b0110; err_set = 1'b1; step(); err_set = 1'b0;
        chk("R9 still held", iir, 8'h02);
        chk("R9 irq live", {7'd0, irq}, 8'h01);
        iir_rd = 1'b0; #1;
        chk("R9 event after read", iir, 8'h06);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk("R10 lsr read clears", iir, 8'h01);
        step(); step();
        chk("R7 no re-arm on held level", iir, 8'h01);
        tx_empty = 1'b0; step();
        tx_empty = 1'b1; step();
        chk("R7 new edge re-arms", iir, 8'h02);
        thr_wr = 1'b1; step(); thr_wr = 1'b0;
        chk("R8 write clears", iir, 8'h01);
        // Read while another code is shown leaves it pending
        tx_empty = 1'b0; step();
        tx_empty = 1'b1; err_set = 1'b1; step(); err_set = 1'b0;
        chk("R1 line over thre", iir, 8'h06);
        iir_rd = 1'b1; step(); iir_rd = 1'b0; step();
        chk("R8 other code read keeps", iir, 8'h06);
        lsr_rd = 1'b1; err_set = 1'b1; step(); lsr_rd = 1'b0; err_set = 1'b0;
        chk("R10 set wins", iir, 8'h06);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk("R8 thre still pending", iir, 8'h02);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule